// File: doc/BRIEF.md
# Defect-Aware ALU Issue Steering

This unit sits between an operation source and a small set of integer ALUs. Each operation carries an operation class, a tag and an operand word. Every cycle the unit picks an ALU for the waiting operation. Its choice follows a health map that is written once the device has been screened. An ALU can be marked clean, marked as having only a broken adder, or switched off. An ALU that is switched off is never handed work. An ALU with a broken adder still takes every class of operation.

When an add operation runs on an ALU with a broken adder, its result is thrown away. The same tag and operand are then sent again, to a clean ALU. So every operation produces exactly one completion, and that completion carries correct data. Each ALU holds one operation at a time. The unit keeps the tag, class and operand of each operation in flight, so that results can be matched, dropped or re-sent without help from the ALUs.

A health map with no clean ALU cannot run an add correctly. Such a map raises a sticky error, and from then on the unit refuses input until reset.

Top module: `alu_issue_steer`

## Requirements
- R1: After reset every health field reads 00 on `cfg_rd`. The field of ALU i sits at bits [2i+1:2i]. The codes are: 00 clean, 01 broken adder only, 11 switched off. Code 10 is handled as switched off.
- R2: A write on `cfg_we` takes effect only when no ALU holds an operation and no re-send is pending. At any other time it is ignored and `cfg_rd` keeps its value.
- R3: An ALU whose field has bit 1 set never sees `iss_valid` raised.
- R4: An incoming operation, of any class, goes to the lowest-index ALU that is free and not switched off. At most one `iss_valid` bit is high in a cycle.
- R5: When no ALU is both free and allowed, `in_ready` stays low and the operation waits. It is issued in the first cycle after such an ALU frees up.
- R6: An add (`in_cls` 00) that completes on an ALU coded 01 produces no completion. It is re-sent with the same tag and operand to the lowest-index free ALU coded 00. While that re-send is pending, `in_ready` is low.
- R7: Each accepted operation completes exactly once on `cmp_valid`, with its own tag and correct result. Operations other than adds complete normally on an ALU coded 01.
- R8: At most one result is taken per cycle. When several ALUs offer results at once, the lowest index is taken first and the others see `res_ready` low.
- R9: `cfg_err` rises as soon as the health map has no ALU coded 00. It stays high until reset, even if a later write supplies a good map. While it is high, `in_ready` is low.
- R10: An ALU receives no new issue until the unit has accepted its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when both are high |
| in_cls | input | 2 | Operation class, 00 = add |
| in_tag | input | TAGW | Operation tag |
| in_opnd | input | OPW | Operand word |
| iss_valid | output | N_ALU | One-hot issue strobe, one bit per ALU |
| iss_cls | output | 2 | Class of the issued operation |
| iss_tag | output | TAGW | Tag of the issued operation |
| iss_opnd | output | OPW | Operand of the issued operation |
| res_valid | input | N_ALU | Result offered by each ALU |
| res_data | input | N_ALU*RESW | Result words, ALU i at bits [i*RESW +: RESW] |
| res_ready | output | N_ALU | Result taken from ALU i |
| cmp_valid | output | 1 | Completion strobe |
| cmp_tag | output | TAGW | Tag of the completing operation |
| cmp_data | output | RESW | Result of the completing operation |
| cfg_we | input | 1 | Health map write strobe |
| cfg_wdata | input | 2*N_ALU | New health map |
| cfg_rd | output | 2*N_ALU | Current health map |
| cfg_err | output | 1 | Sticky unusable-map error |

## Verification
The sharpest corner is an add on the ALU with the broken adder while the clean ALU is still busy. A unit that forwarded the bad result would complete the operation with data off by one. A unit that kept accepting input would let new work slip past the pending re-send. A unit that re-sent to any free ALU would loop the add back onto the broken one. Other tests cover these cases:
- Two results arriving in the same cycle, where a wrong arbiter reverses the completion order.
- A map write while work is in flight, which must leave the map unchanged.
- The reserved code 10, which must behave as switched off.
- Maps with no clean ALU, where a non-sticky flag would drop once a good map was written.

Random streams run under every legal map, checking the data of each tag and its completion count.

// File: rtl/steer_pkg.sv
package steer_pkg;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_LOGIC = 2'b01,
        CLS_SHIFT = 2'b10,
        CLS_CMP   = 2'b11
    } op_cls_e;

    typedef enum logic [1:0] {
        HLTH_OK        = 2'b00,
        HLTH_ADDER_BAD = 2'b01,
        HLTH_RSVD      = 2'b10,
        HLTH_OFF       = 2'b11
    } alu_hlth_e;

    // bit 1 of a health code excludes the ALU entirely (codes 10 and 11)
    function automatic logic hl_usable(input logic [1:0] code);
        return !code[1];
    endfunction

    function automatic logic hl_clean(input logic [1:0] code);
        return code == HLTH_OK;
    endfunction

    function automatic logic hl_adder_bad(input logic [1:0] code);
        return code == HLTH_ADDER_BAD;
    endfunction

endpackage

// File: rtl/steer_lowpick.sv
module steer_lowpick #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // isolate lowest set bit
    assign gnt = req & (~req + {{(N-1){1'b0}}, 1'b1});
    assign any = |req;
endmodule

// File: rtl/steer_slot.sv
module steer_slot #(
    parameter int TAGW = 4,
    parameter int OPW  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            clear,
    input  logic [1:0]      ld_cls,
    input  logic [TAGW-1:0] ld_tag,
    input  logic [OPW-1:0]  ld_opnd,
    output logic            busy,
    output logic [1:0]      cls,
    output logic [TAGW-1:0] tag,
    output logic [OPW-1:0]  opnd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cls  <= '0;
            tag  <= '0;
            opnd <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cls  <= ld_cls;
            tag  <= ld_tag;
            opnd <= ld_opnd;
        end else if (clear) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/steer_cfg.sv
module steer_cfg
    import steer_pkg::*;
#(
    parameter int N = 2,
    localparam int CW = 2 * N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_val,
    input  logic          idle,
    output logic [CW-1:0] codes,
    output logic          err
);
    logic [CW-1:0] codes_q;
    logic          err_q;
    logic          any_clean;

    always_ff @(posedge clk) begin
        if (rst) begin
            codes_q <= '0;
        end else if (wr_en && idle) begin
            codes_q <= wr_val;
        end
    end

    // a map with no clean ALU cannot run adds (and covers the all-off map)
    always_comb begin
        any_clean = 1'b0;
        for (int i = 0; i < N; i++) begin
            any_clean = any_clean | hl_clean(codes_q[2*i +: 2]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q | !any_clean;
    end

    assign codes = codes_q;
    assign err   = err_q | !any_clean;

    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(codes_q));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

// File: rtl/alu_issue_steer.sv
module alu_issue_steer
    import steer_pkg::*;
#(
    parameter int N_ALU = 2,
    parameter int TAGW  = 4,
    parameter int OPW   = 16,
    parameter int RESW  = 8,
    localparam int CW   = 2 * N_ALU
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [1:0]             in_cls,
    input  logic [TAGW-1:0]        in_tag,
    input  logic [OPW-1:0]         in_opnd,
    output logic [N_ALU-1:0]       iss_valid,
    output logic [1:0]             iss_cls,
    output logic [TAGW-1:0]        iss_tag,
    output logic [OPW-1:0]         iss_opnd,
    input  logic [N_ALU-1:0]       res_valid,
    input  logic [N_ALU*RESW-1:0]  res_data,
    output logic [N_ALU-1:0]       res_ready,
    output logic                   cmp_valid,
    output logic [TAGW-1:0]        cmp_tag,
    output logic [RESW-1:0]        cmp_data,
    input  logic                   cfg_we,
    input  logic [CW-1:0]          cfg_wdata,
    output logic [CW-1:0]          cfg_rd,
    output logic                   cfg_err
);
    logic [CW-1:0]    codes;
    logic [N_ALU-1:0] busy, use_free, clean_free, drop, rcand, pick_req, isel;
    logic             iany, rany, in_fire, rp_fire, idle;
    logic [1:0]       s_cls  [N_ALU];
    logic [TAGW-1:0]  s_tag  [N_ALU];
    logic [OPW-1:0]   s_opnd [N_ALU];

    // pending re-send of an add whose result was dropped
    logic             rp_v;
    logic [TAGW-1:0]  rp_tag;
    logic [OPW-1:0]   rp_opnd;

    logic [TAGW-1:0]  sel_tag;
    logic [OPW-1:0]   sel_opnd;
    logic [RESW-1:0]  sel_data;
    logic             sel_drop;

    assign idle = !(|busy) && !rp_v;

    steer_cfg #(.N(N_ALU)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_val(cfg_wdata),
        .idle(idle), .codes(codes), .err(cfg_err)
    );
    assign cfg_rd = codes;

    always_comb begin
        for (int i = 0; i < N_ALU; i++) begin
            use_free[i]   = !busy[i] && hl_usable(codes[2*i +: 2]);
            clean_free[i] = !busy[i] && hl_clean(codes[2*i +: 2]);
            drop[i]       = (s_cls[i] == CLS_ADD) && hl_adder_bad(codes[2*i +: 2]);
            // a result to be dropped waits while the re-send slot is full
            rcand[i]      = busy[i] && res_valid[i] && !(drop[i] && rp_v);
        end
    end

    assign pick_req = rp_v ? clean_free : use_free;

    steer_lowpick #(.N(N_ALU)) u_ipick (.req(pick_req), .gnt(isel), .any(iany));
    steer_lowpick #(.N(N_ALU)) u_rpick (.req(rcand), .gnt(res_ready), .any(rany));

    assign in_ready  = !cfg_err && !rp_v && iany;
    assign in_fire   = in_valid && in_ready;
    assign rp_fire   = rp_v && iany;
    assign iss_valid = (in_fire || rp_fire) ? isel : '0;
    assign iss_cls   = rp_v ? CLS_ADD : in_cls;
    assign iss_tag   = rp_v ? rp_tag  : in_tag;
    assign iss_opnd  = rp_v ? rp_opnd : in_opnd;

    always_comb begin
        sel_tag  = '0;
        sel_opnd = '0;
        sel_data = '0;
        sel_drop = 1'b0;
        for (int i = 0; i < N_ALU; i++) begin
            if (res_ready[i]) begin
                sel_tag  = sel_tag  | s_tag[i];
                sel_opnd = sel_opnd | s_opnd[i];
                sel_data = sel_data | res_data[i*RESW +: RESW];
                sel_drop = sel_drop | drop[i];
            end
        end
    end

    assign cmp_valid = rany && !sel_drop;
    assign cmp_tag   = sel_tag;
    assign cmp_data  = sel_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_v    <= 1'b0;
            rp_tag  <= '0;
            rp_opnd <= '0;
        end else if (rp_fire) begin
            rp_v <= 1'b0;
        end else if (rany && sel_drop) begin
            rp_v    <= 1'b1;
            rp_tag  <= sel_tag;
            rp_opnd <= sel_opnd;
        end
    end

    for (genvar g = 0; g < N_ALU; g++) begin : g_slot
        steer_slot #(.TAGW(TAGW), .OPW(OPW)) u_slot (
            .clk(clk), .rst(rst), .load(iss_valid[g]), .clear(res_ready[g]),
            .ld_cls(iss_cls), .ld_tag(iss_tag), .ld_opnd(iss_opnd),
            .busy(busy[g]), .cls(s_cls[g]), .tag(s_tag[g]), .opnd(s_opnd[g])
        );

        assert_never_off_R3: assert property (@(posedge clk) disable iff (rst)
            iss_valid[g] |-> !codes[2*g+1]);

        assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
            iss_valid[g] |-> !busy[g]);

        assert_resend_clean_R6: assert property (@(posedge clk) disable iff (rst)
            (rp_v && iss_valid[g]) |-> (codes[2*g +: 2] == 2'b00));
    end

    assert_single_issue_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(iss_valid));

    assert_single_take_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(res_ready));
endmodule

// File: tb/sim_alu_issue_steer.sv
module sim_alu_issue_steer;
    localparam int N = 2, TAGW = 4, OPW = 16, RESW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic in_valid = 1'b0, in_ready;
    logic [1:0] in_cls = '0;
    logic [TAGW-1:0] in_tag = '0;
    logic [OPW-1:0] in_opnd = '0;
    logic [N-1:0] iss_valid, res_ready;
    logic [1:0] iss_cls;
    logic [TAGW-1:0] iss_tag, cmp_tag;
    logic [OPW-1:0] iss_opnd;
    logic [N-1:0] m_busy, m_rv;
    logic [N*RESW-1:0] res_data;
    logic cmp_valid, cfg_we = 1'b0, cfg_err;
    logic [RESW-1:0] cmp_data;
    logic [2*N-1:0] cfg_wdata = '0, cfg_rd;

    alu_issue_steer #(.N_ALU(N), .TAGW(TAGW), .OPW(OPW), .RESW(RESW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_tag(in_tag), .in_opnd(in_opnd),
        .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_tag(iss_tag), .iss_opnd(iss_opnd),
        .res_valid(m_rv), .res_data(res_data), .res_ready(res_ready),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_err(cfg_err)
    );

    int total = 0, bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [RESW-1:0] ref_res(input logic [1:0] c, input logic [OPW-1:0] o);
        return (c == 2'b00) ? o[15:8] + o[7:0] : o[15:8] ^ o[7:0];
    endfunction

    // ALU models: a broken-adder ALU (bench code 01) returns add results off by one
    int m_cnt[N];
    logic [RESW-1:0] m_data[N];
    int lat[N];
    bit rnd_lat = 0;
    logic [1:0] bcode[N];
    assign res_data = {m_data[1], m_data[0]};

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                m_busy[i] <= 1'b0;
                m_rv[i]   <= 1'b0;
            end else if (iss_valid[i] && !m_busy[i]) begin
                m_busy[i] <= 1'b1;
                m_cnt[i]  <= (rnd_lat ? int'($urandom_range(1, 4)) : lat[i]) - 1;
                m_data[i] <= ref_res(iss_cls, iss_opnd) +
                             ((iss_cls == 2'b00 && bcode[i] == 2'b01) ? 8'd1 : 8'd0);
            end else if (m_busy[i] && !m_rv[i]) begin
                if (m_cnt[i] == 0) m_rv[i] <= 1'b1;
                else               m_cnt[i] <= m_cnt[i] - 1;
            end else if (m_rv[i] && res_ready[i]) begin
                m_rv[i]   <= 1'b0;
                m_busy[i] <= 1'b0;
            end
        end
    end

    // scoreboard and monitor
    int comp_cnt[16];
    logic [RESW-1:0] comp_val[16];
    logic [RESW-1:0] exp_val[16];
    bit exp_set[16];
    int ord_tag[64];
    int ord_n = 0, bad_iss = 0;
    int iss_n[N];
    logic [TAGW-1:0] last_tag[N];

    always @(negedge clk) begin
        #3;
        if (!rst) begin
            if (cmp_valid) begin
                comp_cnt[cmp_tag]++;
                comp_val[cmp_tag] = cmp_data;
                if (ord_n < 64) ord_tag[ord_n] = int'(cmp_tag);
                ord_n++;
            end
            for (int i = 0; i < N; i++) begin
                if (iss_valid[i]) begin
                    iss_n[i]++;
                    last_tag[i] = iss_tag;
                    if (bcode[i][1]) bad_iss++;
                end
            end
        end
    end

    task automatic sb_clear();
        for (int t = 0; t < 16; t++) begin
            comp_cnt[t] = 0;
            exp_set[t]  = 0;
        end
        ord_n = 0;
        for (int i = 0; i < N; i++) iss_n[i] = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < N; i++) bcode[i] = 2'b00;
        sb_clear();
    endtask

    task automatic cfg_write(input logic [2*N-1:0] v, input bit upd);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        #1 cfg_we = 1'b0;
        if (upd) for (int i = 0; i < N; i++) bcode[i] = v[2*i +: 2];
    endtask

    task automatic send(input logic [1:0] c, input logic [TAGW-1:0] t, input logic [OPW-1:0] o, output int alu);
        int w = 0;
        alu = -1;
        @(negedge clk);
        in_valid = 1'b1; in_cls = c; in_tag = t; in_opnd = o;
        exp_val[t] = ref_res(c, o);
        exp_set[t] = 1;
        #1;
        while (!in_ready && w < 500) begin
            @(negedge clk);
            #1;
            w++;
        end
        if (in_ready) begin
            for (int i = 0; i < N; i++) if (iss_valid[i]) alu = i;
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic probe(input logic [1:0] c, output logic r);
        @(negedge clk);
        in_valid = 1'b1;
        in_cls = c;
        #1 r = in_ready;
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        int w = 0;
        bit d;
        do begin
            @(negedge clk);
            #4;
            d = 1;
            for (int t = 0; t < 16; t++) if (exp_set[t] && comp_cnt[t] == 0) d = 0;
            w++;
        end while (!d && w < 2000);
        repeat (3) @(negedge clk);
    endtask

    task automatic verify(input string req);
        int m = 0;
        for (int t = 0; t < 16; t++) begin
            if (exp_set[t] && (comp_cnt[t] != 1 || comp_val[t] != exp_val[t])) m++;
            if (!exp_set[t] && comp_cnt[t] != 0) m++;
        end
        chk(m == 0, req, "tags with wrong completion count or data", m, 0);
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R5", "in_ready after reset", int'(in_ready), 1);
        chk(cfg_rd == '0, "R1", "map after reset", int'(cfg_rd), 0);
        chk(cfg_err == 1'b0, "R9", "cfg_err after reset", int'(cfg_err), 0);
        chk(iss_valid == '0 && cmp_valid == 1'b0, "R4", "idle strobes", int'(iss_valid), 0);
    endtask

    task automatic t_lowest();
        int a;
        logic r;
        lat[0] = 10; lat[1] = 10;
        send(2'b00, 4'd1, 16'h0304, a);
        chk(a == 0, "R4", "first op ALU", a, 0);
        send(2'b01, 4'd2, 16'h0F0A, a);
        chk(a == 1, "R4", "second op ALU", a, 1);
        probe(2'b10, r);
        chk(r == 1'b0, "R5", "ready with both ALUs busy", int'(r), 0);
        send(2'b10, 4'd3, 16'h5511, a);
        chk(a == 0, "R10", "held op goes to first freed ALU", a, 0);
        wait_done();
        verify("R7");
        sb_clear();
    endtask

    task automatic t_disabled();
        int a;
        lat[0] = 3; lat[1] = 3;
        cfg_write(4'b0011, 1);
        chk(cfg_rd == 4'b0011, "R1", "ALU0 field at bits 1:0", int'(cfg_rd), 3);
        send(2'b01, 4'd4, 16'h1234, a);
        chk(a == 1, "R3", "op avoids switched-off ALU0", a, 1);
        send(2'b00, 4'd5, 16'h2222, a);
        chk(a == 1, "R3", "add waits for ALU1", a, 1);
        wait_done();
        cfg_write(4'b1000, 1);
        send(2'b00, 4'd6, 16'h0101, a);
        send(2'b01, 4'd7, 16'h0101, a);
        chk(a == 0, "R3", "code 10 treated as off", a, 0);
        wait_done();
        chk(bad_iss == 0, "R3", "issues to excluded ALUs", bad_iss, 0);
        verify("R7");
        sb_clear();
    endtask

    task automatic t_resend();
        int a;
        logic r;
        lat[0] = 2; lat[1] = 20;
        cfg_write(4'b0001, 1);
        send(2'b00, 4'd8, 16'h7F01, a);
        chk(a == 0, "R6", "add first lands on broken-adder ALU", a, 0);
        send(2'b01, 4'd9, 16'h00FF, a);
        chk(a == 1, "R4", "second op to ALU1", a, 1);
        repeat (5) @(negedge clk);
        probe(2'b01, r);
        chk(r == 1'b0, "R6", "ready while re-send pending", int'(r), 0);
        chk(comp_cnt[8] == 0, "R6", "dropped result completions", comp_cnt[8], 0);
        wait_done();
        chk(comp_cnt[8] == 1, "R6", "re-sent add completions", comp_cnt[8], 1);
        chk(comp_val[8] == exp_val[8], "R6", "re-sent add data", int'(comp_val[8]), int'(exp_val[8]));
        chk(last_tag[1] == 4'd8 && iss_n[1] == 2, "R6", "re-send tag on ALU1", int'(last_tag[1]), 8);
        lat[1] = 2;
        send(2'b11, 4'd10, 16'h3C0F, a);
        chk(a == 0, "R7", "non-add on broken-adder ALU", a, 0);
        wait_done();
        verify("R7");
        sb_clear();
    endtask

    task automatic t_arb();
        int a;
        lat[0] = 5; lat[1] = 4;
        cfg_write(4'b0000, 1);
        send(2'b01, 4'd11, 16'h1111, a);
        send(2'b01, 4'd12, 16'h2222, a);
        wait_done();
        chk(ord_tag[0] == 11, "R8", "first completion of a same-cycle pair", ord_tag[0], 11);
        chk(ord_tag[1] == 12, "R8", "second completion", ord_tag[1], 12);
        verify("R7");
        sb_clear();
    endtask

    task automatic t_cfg_busy();
        int a;
        lat[0] = 30; lat[1] = 30;
        send(2'b00, 4'd13, 16'h0909, a);
        cfg_write(4'b0011, 0);
        chk(cfg_rd == 4'b0000, "R2", "map after write while busy", int'(cfg_rd), 0);
        wait_done();
        cfg_write(4'b0100, 1);
        chk(cfg_rd == 4'b0100, "R2", "map after write while idle", int'(cfg_rd), 4);
        verify("R7");
        sb_clear();
    endtask

    task automatic t_random();
        logic [3:0] maps[5] = '{4'b0000, 4'b0001, 4'b0100, 4'b0011, 4'b1100};
        int a;
        rnd_lat = 1;
        for (int k = 0; k < 5; k++) begin
            cfg_write(maps[k], 1);
            bad_iss = 0;
            for (int b = 0; b < 2; b++) begin
                for (int t = 0; t < 16; t++) begin
                    send(2'($urandom_range(0, 3)), 4'(t), 16'($urandom), a);
                end
                wait_done();
                verify("R7");
                sb_clear();
            end
            chk(bad_iss == 0, "R3", "random issues to excluded ALUs", bad_iss, 0);
        end
        rnd_lat = 0;
    endtask

    task automatic t_err();
        logic r;
        cfg_write(4'b1111, 1);
        chk(cfg_err == 1'b1, "R9", "error with every ALU off", int'(cfg_err), 1);
        probe(2'b01, r);
        chk(r == 1'b0, "R9", "ready while error", int'(r), 0);
        cfg_write(4'b0000, 1);
        chk(cfg_err == 1'b1, "R9", "error sticky after good map", int'(cfg_err), 1);
        do_reset();
        chk(cfg_err == 1'b0, "R9", "error cleared by reset", int'(cfg_err), 0);
        cfg_write(4'b0101, 1);
        chk(cfg_err == 1'b1, "R9", "error with no clean ALU", int'(cfg_err), 1);
        probe(2'b00, r);
        chk(r == 1'b0, "R9", "add refused with no clean ALU", int'(r), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            lat[i] = 2;
            last_tag[i] = '0;
        end
        do_reset();
        t_reset();
        t_lowest();
        t_disabled();
        t_resend();
        t_arb();
        t_cfg_busy();
        t_random();
        t_err();
        do_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule